// File: doc/BRIEF.md
# Byte-Lane SRAM Bus Timing Monitor

This block watches the control, address and data-drive signals of an asynchronous static memory with a 16-bit data path split into two byte lanes. It takes no part in bus traffic. Every pin is sampled on a fast reference clock. Each sample is decoded into a bus mode, and every interval that matters for a write or a cycle is measured in clock ticks by a bank of run-length counters.

When a minimum timing limit is missed, the monitor latches a sticky violation record. The record holds a 4-bit rule code and the tick count that was measured, and it is kept until the clear input is raised. A separate one-cycle output shows every sample on which the host and the memory would both drive the data lines. Each limit is given in nanoseconds and turned into ticks by rounding up against the clock period. With the defaults (10 ns clock), the write-side limits are 16 ticks, the cycle limit is 20 ticks, the turn-off window after write enable falls is 5 ticks and the turn-on delay after output enable falls is 2 ticks.

Inputs are taken to be synchronous to `clk`. Mode decoding appears one clock after a pin change. A violation or clash appears two clocks after the sample that causes it.

Top module: `sram_bus_monitor`

## Requirements
- R1: `bus_mode` decodes the previous sample: 0 when select is high; otherwise, with write low, 5 for both lanes low, 3 for only the low lane, 4 for only the high lane and 1 for no lane; with write high, 2 when output enable is low and at least one lane is low, otherwise 1.
- R2: After reset, and one clock after `clr` is sampled high, `viol_flag`, `viol_code` and `viol_ticks` are zero. A latched record stays unchanged until `clr` is raised.
- R3: A write is select low, write low and at least one lane low. At the write end, if the address has been stable for fewer than 16 samples, code 1 is raised with that count.
- R4: At the write end, if select has been low for fewer than 16 samples, code 2 is raised with that count.
- R5: At the write end, if write enable has been low for fewer than 16 samples, code 3 is raised with that count.
- R6: At the write end, if the byte enables have been active for fewer than 16 samples, code 4 is raised with that count.
- R7: At the write end, if `host_drive` has been high for fewer than 16 samples (data setup), code 5 is raised with that count.
- R8: If the address changes while select is low on both this sample and the previous one, and the old address was held for fewer than 20 samples, code 6 is raised with the held count.
- R9: An address change between two samples that are both inside a write raises code 7.
- R10: During a read (select, output enable and a lane low, write high), the memory counts as driving once output enable has been low for at least 2 earlier samples. `host_drive` high in that state pulses `bus_clash` and raises code 8, with the count of earlier output-enable-low samples.
- R11: With select, output enable and a lane low, the memory still counts as driving on the first 5 samples after write enable falls. `host_drive` high there raises code 8, with the count of earlier write-low samples.
- R12: Only the first violation after a clear is kept. When several rules fire on the same sample, the lowest code wins.
- R13: The write end is the first sample on which select or write goes high, or on which an active lane enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears the latched violation record |
| sel_n | input | 1 | Memory select, active low |
| wr_n | input | 1 | Write strobe, active low |
| out_en_n | input | 1 | Memory output enable, active low |
| hi_en_n | input | 1 | Upper byte lane enable, active low |
| lo_en_n | input | 1 | Lower byte lane enable, active low |
| mem_addr | input | ADDR_W | Address lines |
| host_drive | input | 1 | High while the host drives the data lines |
| bus_mode | output | 3 | Decoded mode of the previous sample |
| bus_clash | output | 1 | One-cycle pulse per sample with two drivers |
| viol_flag | output | 1 | A violation record is held |
| viol_code | output | 4 | Rule code of the held record, 0 when none |
| viol_ticks | output | CNT_W | Tick count measured for the held record |

## Verification
The assertions assume that the bus pins are already synchronous to `clk`. They also assume that `clr` is the only means of releasing a record, so a held code may change only through a clear. The stimulus drives every pin on the falling clock edge and holds it for whole samples. It builds each write from one duration per signal, with all the signals that end the write rising together. This puts each measured interval on an exact, known tick count, and the sweeps step that count across each limit.

// File: rtl/sram_mon_pkg.sv
// Shared types and helpers for the byte-lane SRAM bus monitor.
// Assumes one sampling clock; all limits are converted to ticks by ceiling division.
package sram_mon_pkg;

    // Decoded bus mode, one value per sample.
    typedef enum logic [2:0] {
        MODE_DESEL   = 3'd0,
        MODE_OUT_OFF = 3'd1,
        MODE_READ    = 3'd2,
        MODE_WR_LO   = 3'd3,
        MODE_WR_HI   = 3'd4,
        MODE_WR_BOTH = 3'd5
    } bus_mode_e;

    // Number of timing rules; rule index i reports code i+1, lower code wins.
    localparam int NUM_RULES = 8;

    // Snapshot of the single-bit bus pins.
    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic out_en_n;
        logic hi_en_n;
        logic lo_en_n;
        logic host_drive;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, out_en_n: 1'b1,
                                    hi_en_n: 1'b1, lo_en_n: 1'b1, host_drive: 1'b0};

    // Round a nanosecond limit up to whole clock ticks.
    function automatic int ns_to_ticks(int ns, int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/sram_mode_decode.sv
// Decodes one pin snapshot into a bus mode, a write-active flag and a lane-active flag.
// Purely combinational; assumes active-low controls.
module sram_mode_decode
    import sram_mon_pkg::*;
(
    input  pins_t     pins,
    output bus_mode_e mode,
    output logic      wr_act,
    output logic      lane_any
);

    // Classify the snapshot by the select / write / output-enable / lane table.
    always_comb begin
        lane_any = !pins.hi_en_n || !pins.lo_en_n;
        wr_act   = !pins.sel_n && !pins.wr_n && lane_any;
        if (pins.sel_n) begin
            mode = MODE_DESEL;
        end else if (!pins.wr_n) begin
            case ({pins.hi_en_n, pins.lo_en_n})
                2'b00:   mode = MODE_WR_BOTH;
                2'b10:   mode = MODE_WR_LO;
                2'b01:   mode = MODE_WR_HI;
                default: mode = MODE_OUT_OFF;
            endcase
        end else if (!pins.out_en_n && lane_any) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_OUT_OFF;
        end
    end

endmodule

// File: rtl/sram_tick_counter.sv
// Saturating run-length counter: counts consecutive samples while run is high,
// returns to zero when run drops, and loads one when restart is raised.
module sram_tick_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    // Advance, restart or drop the run length each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= W'(1);
        end else if (!run) begin
            count <= '0;
        end else if (count != TOP) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/sram_viol_latch.sv
// Holds the first violation seen after reset or clear. Among rules that fire
// together the lowest index (lowest code) is chosen. Clear takes precedence.
module sram_viol_latch
    import sram_mon_pkg::*;
#(
    parameter int N = NUM_RULES,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [N-1:0]        hit,
    input  logic [N-1:0][W-1:0] ticks,
    output logic                flag,
    output logic [3:0]          code,
    output logic [W-1:0]        held_ticks
);

    logic [3:0]   pick_code;
    logic [W-1:0] pick_ticks;

    // Priority pick: scanning downward leaves the lowest firing index.
    always_comb begin
        pick_code  = '0;
        pick_ticks = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                pick_code  = 4'(i + 1);
                pick_ticks = ticks[i];
            end
        end
    end

    // Sticky record, released only by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flag       <= 1'b0;
            code       <= '0;
            held_ticks <= '0;
        end else if (!flag && (|hit)) begin
            flag       <= 1'b1;
            code       <= pick_code;
            held_ticks <= pick_ticks;
        end
    end

endmodule

// File: rtl/sram_bus_monitor.sv
// Passive timing monitor for an asynchronous byte-lane SRAM bus.
// Samples all pins each clock, measures run lengths in ticks, checks write-end,
// cycle, address-stability and bus-contention rules, and latches the first miss.
// Assumes the pins are synchronous to clk; data contents are not examined.
module sram_bus_monitor
    import sram_mon_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int CLK_NS  = 10,
    parameter int AW_NS   = 160,
    parameter int SEL_NS  = 160,
    parameter int PWE_NS  = 160,
    parameter int LANE_NS = 160,
    parameter int SD_NS   = 160,
    parameter int CYC_NS  = 200,
    parameter int HZWE_NS = 50,
    parameter int LZOE_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              out_en_n,
    input  logic              hi_en_n,
    input  logic              lo_en_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              host_drive,
    output logic [2:0]        bus_mode,
    output logic              bus_clash,
    output logic              viol_flag,
    output logic [3:0]        viol_code,
    output logic [CNT_W-1:0]  viol_ticks
);

    localparam logic [CNT_W-1:0] AW_T   = CNT_W'(ns_to_ticks(AW_NS,   CLK_NS));
    localparam logic [CNT_W-1:0] SEL_T  = CNT_W'(ns_to_ticks(SEL_NS,  CLK_NS));
    localparam logic [CNT_W-1:0] PWE_T  = CNT_W'(ns_to_ticks(PWE_NS,  CLK_NS));
    localparam logic [CNT_W-1:0] LANE_T = CNT_W'(ns_to_ticks(LANE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] SD_T   = CNT_W'(ns_to_ticks(SD_NS,   CLK_NS));
    localparam logic [CNT_W-1:0] CYC_T  = CNT_W'(ns_to_ticks(CYC_NS,  CLK_NS));
    localparam logic [CNT_W-1:0] HZWE_T = CNT_W'(ns_to_ticks(HZWE_NS, CLK_NS));
    localparam logic [CNT_W-1:0] LZOE_T = CNT_W'(ns_to_ticks(LZOE_NS, CLK_NS));

    // Counter slots.
    localparam int NCNT   = 6;
    localparam int C_SEL  = 0;
    localparam int C_WR   = 1;
    localparam int C_LANE = 2;
    localparam int C_DRV  = 3;
    localparam int C_OE   = 4;
    localparam int C_ADDR = 5;

    pins_t             pin_now;
    pins_t             cur;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] prv_addr;
    logic              prv_sel_n;
    logic              prv_hi_n;
    logic              prv_lo_n;
    logic              wr_prv;

    bus_mode_e         mode_cur;
    logic              wr_cur;
    logic              lane_cur;

    assign pin_now = '{sel_n: sel_n, wr_n: wr_n, out_en_n: out_en_n,
                       hi_en_n: hi_en_n, lo_en_n: lo_en_n, host_drive: host_drive};

    // Capture the current sample of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur      <= PINS_IDLE;
            cur_addr <= '0;
        end else begin
            cur      <= pin_now;
            cur_addr <= mem_addr;
        end
    end

    // Keep the bits of the previous sample that edge detection needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_addr  <= '0;
            prv_sel_n <= 1'b1;
            prv_hi_n  <= 1'b1;
            prv_lo_n  <= 1'b1;
            wr_prv    <= 1'b0;
        end else begin
            prv_addr  <= cur_addr;
            prv_sel_n <= cur.sel_n;
            prv_hi_n  <= cur.hi_en_n;
            prv_lo_n  <= cur.lo_en_n;
            wr_prv    <= wr_cur;
        end
    end

    sram_mode_decode u_decode (
        .pins     (cur),
        .mode     (mode_cur),
        .wr_act   (wr_cur),
        .lane_any (lane_cur)
    );

    assign bus_mode = mode_cur;

    logic                        addr_chg;
    logic [NCNT-1:0]             run_v;
    logic [NCNT-1:0]             restart_v;
    logic [NCNT-1:0][CNT_W-1:0]  cnt_v;

    assign addr_chg  = (cur_addr != prv_addr);
    assign run_v     = {1'b1, !cur.out_en_n, cur.host_drive, lane_cur, !cur.wr_n, !cur.sel_n};
    assign restart_v = {addr_chg, {(NCNT-1){1'b0}}};

    // One run-length counter per measured signal.
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        sram_tick_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run_v[g]),
            .restart (restart_v[g]),
            .count   (cnt_v[g])
        );
    end

    logic                            wr_end;
    logic                            mem_drive;
    logic                            clash_now;
    logic [NUM_RULES-1:0]            hit;
    logic [NUM_RULES-1:0][CNT_W-1:0] hit_ticks;

    // Write end: first deassertion of select, write, or a lane that was active.
    assign wr_end = wr_prv && (cur.sel_n || cur.wr_n ||
                               (!prv_hi_n && cur.hi_en_n) ||
                               (!prv_lo_n && cur.lo_en_n));

    // Memory drive model: on after output-enable delay, lingers briefly after write falls.
    always_comb begin
        mem_drive = 1'b0;
        if (!cur.sel_n && !cur.out_en_n && lane_cur) begin
            mem_drive = cur.wr_n ? (cnt_v[C_OE] >= LZOE_T) : (cnt_v[C_WR] < HZWE_T);
        end
        clash_now = mem_drive && cur.host_drive;
    end

    // Rule evaluation, index i reports code i+1.
    always_comb begin
        hit[0] = wr_end && (cnt_v[C_ADDR] < AW_T);
        hit[1] = wr_end && (cnt_v[C_SEL]  < SEL_T);
        hit[2] = wr_end && (cnt_v[C_WR]   < PWE_T);
        hit[3] = wr_end && (cnt_v[C_LANE] < LANE_T);
        hit[4] = wr_end && (cnt_v[C_DRV]  < SD_T);
        hit[5] = addr_chg && !cur.sel_n && !prv_sel_n && (cnt_v[C_ADDR] < CYC_T);
        hit[6] = addr_chg && wr_cur && wr_prv;
        hit[7] = clash_now;
        hit_ticks[0] = cnt_v[C_ADDR];
        hit_ticks[1] = cnt_v[C_SEL];
        hit_ticks[2] = cnt_v[C_WR];
        hit_ticks[3] = cnt_v[C_LANE];
        hit_ticks[4] = cnt_v[C_DRV];
        hit_ticks[5] = cnt_v[C_ADDR];
        hit_ticks[6] = cnt_v[C_ADDR];
        hit_ticks[7] = cur.wr_n ? cnt_v[C_OE] : cnt_v[C_WR];
    end

    // Per-sample contention pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_clash <= 1'b0;
        end else begin
            bus_clash <= clash_now;
        end
    end

    sram_viol_latch #(.N(NUM_RULES), .W(CNT_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .hit        (hit),
        .ticks      (hit_ticks),
        .flag       (viol_flag),
        .code       (viol_code),
        .held_ticks (viol_ticks)
    );

endmodule

// File: rtl/sram_bus_monitor_chk.sv
// Port-level properties of the bus monitor, attached by bind.
// Assumes pins are synchronous to clk and clr is the only release of a record.
module sram_bus_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       sel_n,
    input logic [2:0] bus_mode,
    input logic       bus_clash,
    input logic       viol_flag,
    input logic [3:0] viol_code
);

    // R1: a deselected sample decodes as mode 0 one clock later.
    a_r1_desel_mode: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (bus_mode == 3'd0));

    // R2: a held record does not change without a clear.
    a_r2_record_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clr) |=> (viol_flag && $stable(viol_code)));

    // R2: clear empties the record.
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!viol_flag && viol_code == 4'd0));

    // R12: a held code is a legal rule code.
    a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |-> (viol_code != 4'd0 && viol_code <= 4'd8));

    // R12: no code without a record.
    a_r12_no_stray_code: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_flag |-> (viol_code == 4'd0));

    // R10: a contention pulse always leaves a record unless it was cleared.
    a_r10_clash_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clash |-> (viol_flag || $past(clr)));

    // R11: a deselected bus never shows contention.
    a_r11_desel_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> ##2 !bus_clash);

endmodule

bind sram_bus_monitor sram_bus_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .sel_n     (sel_n),
    .bus_mode  (bus_mode),
    .bus_clash (bus_clash),
    .viol_flag (viol_flag),
    .viol_code (viol_code)
);

// File: tb/sram_bus_monitor_tb.sv
// Sweeps each timing rule across its limit and the full mode table.
module sram_bus_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        hi_en_n = 1'b1;
    logic        lo_en_n = 1'b1;
    logic [15:0] mem_addr = 16'h0000;
    logic        host_drive = 1'b0;
    logic [2:0]  bus_mode;
    logic        bus_clash;
    logic        viol_flag;
    logic [3:0]  viol_code;
    logic [15:0] viol_ticks;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_bus_monitor u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .sel_n      (sel_n),
        .wr_n       (wr_n),
        .out_en_n   (out_en_n),
        .hi_en_n    (hi_en_n),
        .lo_en_n    (lo_en_n),
        .mem_addr   (mem_addr),
        .host_drive (host_drive),
        .bus_mode   (bus_mode),
        .bus_clash  (bus_clash),
        .viol_flag  (viol_flag),
        .viol_code  (viol_code),
        .viol_ticks (viol_ticks)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic go_idle();
        sel_n = 1'b1; wr_n = 1'b1; out_en_n = 1'b1;
        hi_en_n = 1'b1; lo_en_n = 1'b1; host_drive = 1'b0;
    endtask

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Clear the record and leave the bus idle long enough to forget history.
    task automatic settle();
        go_idle();
        clr = 1'b1;
        tick();
        clr = 1'b0;
        repeat (23) tick();
    endtask

    function automatic int exp_mode(logic s, logic w, logic o, logic h, logic l);
        if (s) return 0;
        if (!w) begin
            if (!h && !l) return 5;
            if (!l) return 3;
            if (!h) return 4;
            return 1;
        end
        if (!o && (!h || !l)) return 2;
        return 1;
    endfunction

    // Write built from per-signal low durations ending on the same sample.
    task automatic wr_case(string req, int da, int dc, int dw, int db, int dd, logic [15:0] na);
        int mn;
        int ecode;
        int eticks;
        settle();
        for (int i = 0; i < 40; i++) begin
            if (i >= 40 - da) mem_addr = na;
            sel_n      = !(i >= 40 - dc);
            wr_n       = !(i >= 40 - dw);
            hi_en_n    = !(i >= 40 - db);
            lo_en_n    = !(i >= 40 - db);
            host_drive = (i >= 40 - dd);
            tick();
        end
        go_idle();
        tick();
        tick();
        mn = (dc < dw) ? dc : dw;
        mn = (db < mn) ? db : mn;
        ecode = 0; eticks = 0;
        if (da < mn) begin ecode = 7; eticks = -1; end
        else if (da < 16) begin ecode = 1; eticks = da; end
        else if (dc < 16) begin ecode = 2; eticks = dc; end
        else if (dw < 16) begin ecode = 3; eticks = dw; end
        else if (db < 16) begin ecode = 4; eticks = db; end
        else if (dd < 16) begin ecode = 5; eticks = dd; end
        check(req, int'(viol_code), ecode);
        check(req, int'(viol_flag), (ecode != 0) ? 1 : 0);
        if (eticks >= 0) check(req, int'(viol_ticks), eticks);
    endtask

    // Read cycle holding one address for n samples before moving on.
    task automatic rd_case(int n);
        settle();
        sel_n = 1'b0; out_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        mem_addr = 16'h1000 + 16'(n);
        repeat (n) tick();
        mem_addr = ~mem_addr;
        repeat (25) tick();
        go_idle();
        tick();
        tick();
        check("R8", int'(viol_code), (n < 20) ? 6 : 0);
        if (n < 20) check("R8", int'(viol_ticks), n);
    endtask

    // Read with host drive pulsed j samples after output enable falls.
    task automatic oe_case(int j);
        bit seen = 0;
        settle();
        sel_n = 1'b0; out_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        for (int i = 0; i < j + 5; i++) begin
            host_drive = (i == j);
            tick();
            if (bus_clash) seen = 1;
        end
        go_idle();
        tick();
        tick();
        check("R10", int'(viol_code), (j >= 2) ? 8 : 0);
        check("R10", int'(seen), (j >= 2) ? 1 : 0);
        if (j >= 2) check("R10", int'(viol_ticks), j);
    endtask

    // Read turning into a write, host drive starting m samples after write falls.
    task automatic we_case(int m);
        settle();
        sel_n = 1'b0; out_en_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
        repeat (10) tick();
        for (int i = 0; i < 30; i++) begin
            wr_n = 1'b0;
            host_drive = (i >= m);
            tick();
        end
        go_idle();
        tick();
        tick();
        check("R11", int'(viol_code), (m < 5) ? 8 : 0);
        if (m < 5) check("R11", int'(viol_ticks), m);
    endtask

    initial begin
        repeat (4) tick();
        check("R2", int'(viol_flag), 0);
        check("R2", int'(viol_code), 0);
        check("R2", int'(viol_ticks), 0);
        check("R1", int'(bus_mode), 0);
        rst_n = 1'b1;
        tick();
        check("R11", int'(bus_clash), 0);

        // R1: every combination of the five control pins.
        for (int v = 0; v < 32; v++) begin
            sel_n = v[4]; wr_n = v[3]; out_en_n = v[2]; hi_en_n = v[1]; lo_en_n = v[0];
            host_drive = 1'b0;
            tick();
            check("R1", int'(bus_mode), exp_mode(v[4], v[3], v[2], v[1], v[0]));
        end

        // R3, R13: address setup sweep; write starts with the lanes.
        for (int n = 10; n <= 20; n++) wr_case("R3", n, 30, 30, n, 30, 16'(16'h0100 + n));
        // R4: select duration sweep.
        for (int n = 10; n <= 20; n++) wr_case("R4", 30, n, 30, 30, 30, 16'(16'h0200 + n));
        // R5: write strobe sweep.
        for (int n = 10; n <= 20; n++) wr_case("R5", 30, 30, n, 30, 30, 16'(16'h0300 + n));
        // R6: lane enable sweep.
        for (int n = 10; n <= 20; n++) wr_case("R6", 30, 30, 30, n, 30, 16'(16'h0400 + n));
        // R7: data setup sweep.
        for (int n = 10; n <= 20; n++) wr_case("R7", 30, 30, 30, 30, n, 16'(16'h0500 + n));
        // R9: address moves mid-write; the later short setup must not replace it (R12).
        wr_case("R9", 10, 30, 30, 30, 30, 16'h0600);
        // R12: two rules on one sample, lower code wins.
        wr_case("R12", 30, 12, 12, 30, 30, 16'h0700);

        // R8: cycle time sweep.
        for (int n = 15; n <= 24; n++) rd_case(n);
        // R10: output-enable turn-on window.
        for (int j = 0; j <= 4; j++) oe_case(j);
        // R11: write-fall turn-off window.
        for (int m = 0; m <= 7; m++) we_case(m);

        // R2: clear releases a held record.
        wr_case("R2", 30, 30, 10, 30, 30, 16'h0800);
        clr = 1'b1;
        tick();
        clr = 1'b0;
        tick();
        check("R2", int'(viol_flag), 0);
        check("R2", int'(viol_code), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule